// File: doc/BRIEF.md
# Strobe/Ready Register Bus Master

This block is the host side of a register bus that drives a chain of neuron chips. The chips share a 4-bit register address, a 16-bit open-drain data bus, an active-low write line, a data strobe, a ready line that every chip can pull low, and a clock-enable line. A user-side valid/ready port hands the master one command at a time: a read or write flag, an address, and write data. The master issues a single strobe cycle and releases the shared lines straight away, so the chips can use wired-AND snooping while ready is low. It then waits for ready to rise and returns one response pulse.

All bus-side outputs are registered on the falling clock edge, and the chips sample them on the rising edge. The command sequencer runs on the rising edge. Ready and the data bus are sampled on the falling edge, when they are stable. If a command runs past a configurable limit, the master ends it with a timeout response. Parameter `GATE_LEAD` chooses when the clock enable rises: on the same falling edge as the strobe, or one cycle before it.

Top module: `strobe_bus_master`

## Requirements
- R1: Every bus output (strobe, write line, address, data out, data drive enable, clock enable) changes only on a falling clock edge. Between a rising edge and the next falling edge these outputs hold their values.
- R2: The strobe is raised only when ready is high. It stays high for exactly one rising edge, and each accepted command produces exactly one strobe.
- R3: The active-low write line is 0 only in the strobe cycle of a write. At all other times it is 1, and it stays 1 for reads.
- R4: The data drive enable is 1 only in the strobe cycle of a write, and the write data is on the data-out pins in that cycle. The bus is released at the next falling edge, with drive enable 0 and data out all ones.
- R5: The address is presented with the strobe and stays stable until ready rises again.
- R6: For a read, `rsp_rdata` is the bus value sampled on the falling edge after ready rises, and an undriven bus reads as 0xFFFF. For a write, `rsp_rdata` is 0x0000.
- R7: `rsp_valid` is a one-cycle pulse that comes exactly L+2+GATE_LEAD rising edges after the accepting edge, where L is the number of cycles ready stays low.
- R8: The clock enable is high at the rising edge that samples the strobe. When GATE_LEAD=1 it is also high at the rising edge before that. It stays high while ready is low, and it drops on the falling edge after the response once ready is high.
- R9: If ready stays low for more than TIMEOUT_CYC cycles, the response has `rsp_timeout`=1 and `rsp_rdata`=0xFFFF. At exactly TIMEOUT_CYC low cycles the command completes normally with `rsp_timeout`=0.
- R10: `cmd_ready` is 0 from the accepting edge until the response. After the response it also stays 0 for as long as ready is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_timeout | output | 1 | Command ended by timeout |
| bus_strobe | output | 1 | Data strobe |
| bus_wr_n | output | 1 | Write line, low for write |
| bus_addr | output | ADDR_W | Register address lines |
| bus_dq_out | output | DATA_W | Data value to drive |
| bus_dq_oe | output | 1 | Data drive enable |
| bus_dq_in | input | DATA_W | Resolved data bus value |
| bus_ready | input | 1 | Wired ready line from the chain |
| bus_clk_en | output | 1 | Clock enable for the chain |

## Verification
The bench builds the master with GATE_LEAD=1. This exercises the extra arm state and lets it check that the clock enable leads the strobe by one edge. TIMEOUT_CYC stays at 32, so the boundary is quick to reach: a ready pulse 32 cycles long must complete normally, while 33 and 40 cycles must time out. The 40-cycle case also shows the clock enable and `cmd_ready` tracking a ready line that is still low after the response. A bus model with random ready lengths from 1 to 19 cycles resolves the wired-AND data bus and catches any overlap between the master's drive and a chip's reply.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [2:0] {
      SBM_IDLE = 3'd0,
      SBM_ARM  = 3'd1,
      SBM_STRB = 3'd2,
      SBM_WAIT = 3'd3
   } sbm_state_e;
endpackage

// File: rtl/sbm_seq.sv
module sbm_seq
   import sbm_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int TIMEOUT_CYC = 32,
   parameter bit GATE_LEAD   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              rdy_s,
   input  logic [DATA_W-1:0] dq_s,
   output sbm_state_e        state_q,
   output logic              lat_write,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_timeout
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

   sbm_state_e       launch_st;
   logic [CNT_W-1:0] wait_cnt;

   generate
      if (GATE_LEAD) begin : g_lead
         assign launch_st = SBM_ARM;
      end else begin : g_direct
         assign launch_st = SBM_STRB;
      end
   endgenerate

   assign cmd_ready = (state_q == SBM_IDLE) && rdy_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SBM_IDLE;
         wait_cnt    <= '0;
         lat_write   <= 1'b0;
         lat_addr    <= '0;
         lat_wdata   <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         rsp_timeout <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            SBM_IDLE: begin
               if (cmd_valid && cmd_ready) begin
                  lat_write <= cmd_write;
                  lat_addr  <= cmd_addr;
                  lat_wdata <= cmd_wdata;
                  state_q   <= launch_st;
               end
            end
            SBM_ARM: state_q <= SBM_STRB;
            SBM_STRB: begin
               wait_cnt <= '0;
               state_q  <= SBM_WAIT;
            end
            SBM_WAIT: begin
               if (rdy_s) begin
                  rsp_valid   <= 1'b1;
                  rsp_timeout <= 1'b0;
                  rsp_rdata   <= lat_write ? '0 : dq_s;
                  state_q     <= SBM_IDLE;
               end else if (wait_cnt == CNT_MAX) begin
                  rsp_valid   <= 1'b1;
                  rsp_timeout <= 1'b1;
                  rsp_rdata   <= '1;
                  state_q     <= SBM_IDLE;
               end else begin
                  wait_cnt <= wait_cnt + CNT_W'(1);
               end
            end
            default: state_q <= SBM_IDLE;
         endcase
      end
   end

   // R7: the response is a single-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R9: the wait counter never runs past the limit
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= CNT_MAX);

   // R10: no command is accepted while one is in flight
   a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SBM_IDLE) |-> !cmd_ready);

   // R5: the latched address holds during the wait
   a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SBM_WAIT) |-> $stable(lat_addr));
endmodule

// File: rtl/sbm_pins.sv
module sbm_pins
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sbm_state_e        state_q,
   input  logic              lat_write,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] lat_wdata,
   input  logic              bus_ready,
   input  logic [DATA_W-1:0] bus_dq_in,
   output logic              bus_strobe,
   output logic              bus_wr_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dq_out,
   output logic              bus_dq_oe,
   output logic              bus_clk_en,
   output logic              rdy_s,
   output logic [DATA_W-1:0] dq_s
);
   logic wr_cyc;
   assign wr_cyc = (state_q == SBM_STRB) && lat_write;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_strobe <= 1'b0;
         bus_wr_n   <= 1'b1;
         bus_addr   <= '0;
         bus_dq_out <= '1;
         bus_dq_oe  <= 1'b0;
         bus_clk_en <= 1'b0;
         rdy_s      <= 1'b0;
         dq_s       <= '1;
      end else begin
         bus_strobe <= (state_q == SBM_STRB);
         bus_wr_n   <= !wr_cyc;
         bus_dq_oe  <= wr_cyc;
         bus_dq_out <= wr_cyc ? lat_wdata : '1;
         bus_addr   <= lat_addr;
         bus_clk_en <= (state_q != SBM_IDLE) || !bus_ready;
         rdy_s      <= bus_ready;
         dq_s       <= bus_dq_in;
      end
   end

   // R2: the strobe lasts one cycle
   a_r2_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |=> !bus_strobe);

   // R4: data is driven only in a write strobe cycle
   a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dq_oe |-> (bus_strobe && !bus_wr_n));

   // R8: the chain clock is enabled whenever a strobe is sampled
   a_r8_gate_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |-> bus_clk_en);
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
   import sbm_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int TIMEOUT_CYC = 32,
   parameter bit GATE_LEAD   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_timeout,
   output logic              bus_strobe,
   output logic              bus_wr_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dq_out,
   output logic              bus_dq_oe,
   input  logic [DATA_W-1:0] bus_dq_in,
   input  logic              bus_ready,
   output logic              bus_clk_en
);
   generate
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("strobe_bus_master: ADDR_W must be >= 1 and DATA_W >= 2");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("strobe_bus_master: TIMEOUT_CYC must be >= 2");
      end
   endgenerate

   sbm_state_e        state_q;
   logic              lat_write;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic              rdy_s;
   logic [DATA_W-1:0] dq_s;

   sbm_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .TIMEOUT_CYC(TIMEOUT_CYC), .GATE_LEAD(GATE_LEAD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rdy_s(rdy_s), .dq_s(dq_s),
      .state_q(state_q), .lat_write(lat_write),
      .lat_addr(lat_addr), .lat_wdata(lat_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout)
   );

   sbm_pins #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_pins (
      .clk(clk), .rst_n(rst_n),
      .state_q(state_q), .lat_write(lat_write),
      .lat_addr(lat_addr), .lat_wdata(lat_wdata),
      .bus_ready(bus_ready), .bus_dq_in(bus_dq_in),
      .bus_strobe(bus_strobe), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
      .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_clk_en(bus_clk_en),
      .rdy_s(rdy_s), .dq_s(dq_s)
   );

   // R2: a strobe is never sampled while the chain reports busy
   a_r2_strobe_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_strobe) |-> $past(bus_ready));

   // R3: the write line is low only together with the strobe
   a_r3_write_line: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_strobe);
endmodule

// File: tb/strobe_bus_master_bench.sv
module strobe_bus_master_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int DW   = 16;
   localparam int TMO  = 32;
   localparam int LEAD = 1;
   localparam int SNAP_W = AW + DW + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_ready, rsp_valid, rsp_timeout;
   logic [DW-1:0] rsp_rdata;
   logic          bus_strobe, bus_wr_n, bus_dq_oe, bus_clk_en;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dq_out;
   logic [DW-1:0] bus_dq_in;

   // bus model state
   logic          slv_ready = 1'b1;
   int            slv_left = 0;
   logic [AW-1:0] s_addr = '0;
   logic          s_wr = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic [DW-1:0] slave_dq = '1;
   logic          prev_en = 1'b0;
   int            n_strobe = 0;
   int            lat_next = 1;
   bit            mute = 1'b0;
   int            seq = 0;
   int            cyc = 0;
   int            tests = 0;
   int            fails = 0;
   int            n_cmds = 0;

   assign bus_dq_in = (bus_dq_oe ? bus_dq_out : '1) & slave_dq;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   strobe_bus_master #(
      .ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TMO), .GATE_LEAD(1'b1)
   ) u_strobe_bus_master (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .bus_strobe(bus_strobe), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
      .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in),
      .bus_ready(slv_ready), .bus_clk_en(bus_clk_en)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a, input int s);
      return {a, 12'(s)} ^ 16'h5A3C;
   endfunction

   // chain model: ready low for lat_next cycles, replies for one cycle
   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_strobe) begin
            chk(slv_ready, "R2 strobe while ready low", 32'(slv_ready), 32'd1);
            chk(bus_clk_en && (LEAD == 0 || prev_en), "R8 clock enable at strobe",
                {30'd0, prev_en, bus_clk_en}, 32'd3);
            s_addr   <= bus_addr;
            s_wr     <= !bus_wr_n;
            s_data   <= bus_dq_in;
            n_strobe <= n_strobe + 1;
            slv_ready <= 1'b0;
            slv_left  <= lat_next;
            slave_dq  <= '1;
         end else if (!slv_ready) begin
            chk(!bus_dq_oe && bus_wr_n, "R3/R4 lines released while busy",
                {30'd0, bus_dq_oe, bus_wr_n}, 32'd1);
            chk(bus_addr == s_addr, "R5 address stable", 32'(bus_addr), 32'(s_addr));
            chk(bus_clk_en, "R8 clock enable while busy", 32'(bus_clk_en), 32'd1);
            if (slv_left == 1) begin
               slv_ready <= 1'b1;
               if (!s_wr && !mute) slave_dq <= rd_val(s_addr, seq);
            end else begin
               slv_left <= slv_left - 1;
            end
         end else begin
            slave_dq <= '1;
         end
      end
      prev_en <= bus_clk_en;
   end

   // R1: bus outputs do not move just after a rising edge
   always @(posedge clk) begin
      logic [SNAP_W-1:0] snap;
      snap = {bus_strobe, bus_wr_n, bus_addr, bus_dq_out, bus_dq_oe, bus_clk_en};
      #1;
      if (rst_n)
         chk(snap == {bus_strobe, bus_wr_n, bus_addr, bus_dq_out, bus_dq_oe, bus_clk_en},
             "R1 output moved on rising edge",
             32'({bus_strobe, bus_wr_n, bus_addr, bus_dq_out, bus_dq_oe, bus_clk_en}), 32'(snap));
   end

   task automatic run_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int lat, input bit m);
      int acc_cyc;
      int exp_lat;
      bit to;
      logic [DW-1:0] exp_d;
      lat_next = lat;
      mute = m;
      seq++;
      n_cmds++;
      to = (lat > TMO);
      @(negedge clk);
      #1;
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      acc_cyc = cyc;
      cmd_valid = 1'b0;
      chk(!cmd_ready, "R10 busy after accept", 32'(cmd_ready), 32'd0);
      while (!rsp_valid) begin
         @(posedge clk);
         #1;
      end
      exp_lat = to ? (TMO + 2 + LEAD) : (lat + 2 + LEAD);
      chk(cyc - acc_cyc == exp_lat, "R7 response latency", 32'(cyc - acc_cyc), 32'(exp_lat));
      chk(rsp_timeout == to, "R9 timeout flag", 32'(rsp_timeout), 32'(to));
      exp_d = to ? '1 : (wr ? '0 : (m ? '1 : rd_val(a, seq)));
      chk(rsp_rdata == exp_d, "R6 response data", 32'(rsp_rdata), 32'(exp_d));
      if (!to || lat > TMO + 1) begin
         chk(s_addr == a, "R5 address at strobe", 32'(s_addr), 32'(a));
         chk(s_wr == wr, "R3 write line at strobe", 32'(s_wr), 32'(wr));
         if (wr) chk(s_data == d, "R4 write data on bus", 32'(s_data), 32'(d));
      end
      @(posedge clk);
      #1;
      chk(!rsp_valid, "R7 single pulse", 32'(rsp_valid), 32'd0);
      if (lat > TMO + 2) begin
         chk(bus_clk_en, "R8 enable held while ready low", 32'(bus_clk_en), 32'd1);
         chk(!cmd_ready, "R10 no accept while ready low", 32'(cmd_ready), 32'd0);
      end else if (!to) begin
         chk(!bus_clk_en, "R8 enable dropped after response", 32'(bus_clk_en), 32'd0);
      end
      while (!slv_ready) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240);
      repeat (3) @(posedge clk);
      #1;
      chk(!bus_strobe && bus_wr_n && !bus_dq_oe && !bus_clk_en && !rsp_valid,
          "R3/R4/R8 reset state",
          {27'd0, bus_strobe, bus_wr_n, bus_dq_oe, bus_clk_en, rsp_valid}, 32'h8);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(cmd_ready, "R10 ready after reset", 32'(cmd_ready), 32'd1);

      // directed corners
      run_cmd(1'b1, 4'h6, 16'h000B, 1, 1'b0);
      run_cmd(1'b0, 4'h4, 16'h0000, 1, 1'b0);
      run_cmd(1'b0, 4'h3, 16'h0000, 19, 1'b0);
      run_cmd(1'b0, 4'hA, 16'h0000, 5, 1'b1);
      run_cmd(1'b1, 4'hF, 16'h0000, 3, 1'b0);
      run_cmd(1'b1, 4'h0, 16'hFFFF, 2, 1'b0);
      run_cmd(1'b0, 4'h2, 16'h0000, TMO, 1'b0);
      run_cmd(1'b0, 4'h2, 16'h0000, TMO + 1, 1'b0);
      run_cmd(1'b1, 4'h9, 16'h1234, TMO + 8, 1'b0);

      // random mix
      for (int i = 0; i < 40; i++) begin
         run_cmd(1'($urandom), AW'($urandom), DW'($urandom),
                 1 + int'($urandom % 19), ($urandom % 8) == 0);
      end

      chk(n_strobe == n_cmds, "R2 one strobe per command", 32'(n_strobe), 32'(n_cmds));
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule